// File: doc/BRIEF.md
# Speculative Branch Shadow Resolver

This unit settles a single conditional branch inside an out-of-order core where speculative results are held back rather than undone. When a branch is issued to it, the unit records the program counter of the path the front end did not follow and raises one shadow flag. While that flag is up, every operation issued after the branch may compute but may not write its result to registers or memory. Because of this, no register or memory rollback is ever needed.

The unit stays busy until it sees the branch outcome. If the prediction was right, the shadow drops and a one-cycle write release goes to the held-back operations. If the prediction was wrong, the unit sends a one-cycle cancel to every shadowed operation that has not yet completed or is still waiting to write. In the same cycle it gives fetch a one-cycle redirect carrying the recorded address, so that issue resumes on the correct path. All outputs come from registers, and reset is synchronous and active high.

Top module: `branch_shadow_unit`

## Requirements
- R1: One cycle after `rst` is sampled high, `shadow_active`, `go_write`, `cancel` and `redirect_valid` are 0 and `issue_ready` is 1. This holds even if a branch was in flight when reset was applied.
- R2: When `issue_valid` and `issue_ready` are both 1 at a rising edge, `shadow_active` is 1 from the next cycle, and the value on `issue_alt_pc` is stored as the alternative address.
- R3: While `shadow_active` is 1, `issue_ready` is 0. An `issue_valid` in that time is refused and leaves the stored alternative address unchanged, which can be seen on a later `redirect_pc`.
- R4: An outcome sampled while the shadow is active with `resolve_valid`=1 and `resolve_mispredict`=0 (prediction correct) clears `shadow_active` and raises `go_write` in the next cycle. `cancel` and `redirect_valid` stay 0.
- R5: An outcome sampled while the shadow is active with `resolve_valid`=1 and `resolve_mispredict`=1 clears `shadow_active` and raises both `cancel` and `redirect_valid` in the next cycle. In that cycle `redirect_pc` equals the stored alternative address, and `go_write` stays 0.
- R6: `resolve_valid` sampled while `shadow_active` is 0 has no effect: no `go_write`, `cancel` or `redirect_valid` follows.
- R7: `go_write`, `cancel` and `redirect_valid` last exactly one cycle, even if `resolve_valid` is held high for several cycles.
- R8: If a branch is accepted at the same edge as a stale outcome (the unit is idle and `issue_valid` and `resolve_valid` are both 1), the issue takes effect and the outcome does not resolve the new branch.
- R9: A new branch may be accepted in the cycle in which the release or cancel pulse of the previous branch is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | A branch is offered for issue |
| issue_ready | output | 1 | Unit is free to accept a branch |
| issue_alt_pc | input | PC_W | Address of the path not predicted |
| resolve_valid | input | 1 | Branch outcome is present |
| resolve_mispredict | input | 1 | 1: prediction was wrong, 0: prediction was right |
| shadow_active | output | 1 | Shadow over later operations; outcome still undecided |
| go_write | output | 1 | One-cycle release for held-back writes |
| cancel | output | 1 | One-cycle discard of shadowed operations |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | PC_W | Address fetch restarts from |

## Verification
Two cases can fall in one cycle. In the first, a stale outcome arrives while the unit is idle and accepting a branch. In the second, a new branch is offered exactly while the previous branch's release or cancel pulse is high. The bench provokes the first by driving `issue_valid` and `resolve_valid` together on an idle unit, and the second by offering a branch in the cycle after an outcome is sampled. A behavioural model is compared with every output on every clock. It confirms that the new branch raises the shadow without any spurious pulse, and that the old branch's redirect still carries the old address.

// File: rtl/brsu_pkg.sv
`timescale 1ns/1ps
package brsu_pkg;

  typedef enum logic {
    BRSU_IDLE   = 1'b0,
    BRSU_SHADOW = 1'b1
  } brsu_state_e;

  typedef struct packed {
    logic release_wr;
    logic kill;
  } brsu_pulse_t;

endpackage

// File: rtl/brsu_shadow_ctrl.sv
`timescale 1ns/1ps
module brsu_shadow_ctrl
  import brsu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic issue_valid,
  input  logic resolve_valid,
  output logic shadow_o,
  output logic accept_o,
  output logic fire_o
);

  brsu_state_e state_q;

  assign accept_o = issue_valid && (state_q == BRSU_IDLE);
  assign fire_o   = resolve_valid && (state_q == BRSU_SHADOW);
  assign shadow_o = (state_q == BRSU_SHADOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BRSU_IDLE;
    end else if (accept_o) begin
      state_q <= BRSU_SHADOW;
    end else if (fire_o) begin
      state_q <= BRSU_IDLE;
    end
  end

  AST_ISSUE_RAISES_SHADOW: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> shadow_o); // R2

  AST_OUTCOME_DROPS_SHADOW: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !shadow_o); // R4

endmodule

// File: rtl/brsu_alt_pc_reg.sv
`timescale 1ns/1ps
module brsu_alt_pc_reg #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_o
);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (load_i) begin
      pc_q <= pc_i;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/brsu_pulse_gen.sv
`timescale 1ns/1ps
module brsu_pulse_gen
  import brsu_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire_i,
  input  logic            mispredict_i,
  input  logic [PC_W-1:0] alt_pc_i,
  output logic            go_write_o,
  output logic            cancel_o,
  output logic            redirect_valid_o,
  output logic [PC_W-1:0] redirect_pc_o
);

  brsu_pulse_t     pulse_d;
  brsu_pulse_t     pulse_q;
  logic            redir_q;
  logic [PC_W-1:0] rpc_q;

  always_comb begin
    pulse_d.release_wr = fire_i && !mispredict_i;
    pulse_d.kill       = fire_i && mispredict_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= '0;
      redir_q <= 1'b0;
      rpc_q   <= '0;
    end else begin
      pulse_q <= pulse_d;
      redir_q <= pulse_d.kill;
      if (pulse_d.kill) begin
        rpc_q <= alt_pc_i;
      end
    end
  end

  assign go_write_o       = pulse_q.release_wr;
  assign cancel_o         = pulse_q.kill;
  assign redirect_valid_o = redir_q;
  assign redirect_pc_o    = rpc_q;

endmodule

// File: rtl/branch_shadow_unit.sv
`timescale 1ns/1ps
module branch_shadow_unit #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  output logic            issue_ready,
  input  logic [PC_W-1:0] issue_alt_pc,
  input  logic            resolve_valid,
  input  logic            resolve_mispredict,
  output logic            shadow_active,
  output logic            go_write,
  output logic            cancel,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);

  logic            accept;
  logic            fire;
  logic            shadow;
  logic [PC_W-1:0] alt_q;

  brsu_shadow_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .issue_valid   (issue_valid),
    .resolve_valid (resolve_valid),
    .shadow_o      (shadow),
    .accept_o      (accept),
    .fire_o        (fire)
  );

  brsu_alt_pc_reg #(.PC_W(PC_W)) u_alt (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .pc_i   (issue_alt_pc),
    .pc_o   (alt_q)
  );

  brsu_pulse_gen #(.PC_W(PC_W)) u_pulse (
    .clk              (clk),
    .rst              (rst),
    .fire_i           (fire),
    .mispredict_i     (resolve_mispredict),
    .alt_pc_i         (alt_q),
    .go_write_o       (go_write),
    .cancel_o         (cancel),
    .redirect_valid_o (redirect_valid),
    .redirect_pc_o    (redirect_pc)
  );

  assign shadow_active = shadow;
  assign issue_ready   = !shadow;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!shadow_active && !go_write && !cancel && !redirect_valid)); // R1

  AST_BUSY_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
    shadow_active |=> $stable(alt_q)); // R3

  AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    go_write |-> (!cancel && !redirect_valid && !shadow_active)); // R4

  AST_REDIRECT_ADDR: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (cancel && redirect_pc == alt_q)); // R5

  AST_IDLE_OUTCOME_QUIET: assert property (@(posedge clk) disable iff (rst)
    !shadow_active |=> !(go_write || cancel)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (go_write || cancel) |=> !(go_write || cancel)); // R7

  AST_ISSUE_BEATS_STALE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_ready && resolve_valid) |=> (shadow_active && !go_write && !cancel)); // R8

endmodule

// File: tb/test_branch_shadow_unit.sv
`timescale 1ns/1ps
module test_branch_shadow_unit;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            issue_valid;
  logic            issue_ready;
  logic [PC_W-1:0] issue_alt_pc;
  logic            resolve_valid;
  logic            resolve_mispredict;
  logic            shadow_active;
  logic            go_write;
  logic            cancel;
  logic            redirect_valid;
  logic [PC_W-1:0] redirect_pc;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  bit              m_shadow;
  bit              m_go;
  bit              m_cancel;
  logic [PC_W-1:0] m_rpc;
  logic [PC_W-1:0] pend_q[$];

  always #2.5 clk = ~clk;

  branch_shadow_unit #(.PC_W(PC_W)) i_branch_shadow_unit (
    .clk                (clk),
    .rst                (rst),
    .issue_valid        (issue_valid),
    .issue_ready        (issue_ready),
    .issue_alt_pc       (issue_alt_pc),
    .resolve_valid      (resolve_valid),
    .resolve_mispredict (resolve_mispredict),
    .shadow_active      (shadow_active),
    .go_write           (go_write),
    .cancel             (cancel),
    .redirect_valid     (redirect_valid),
    .redirect_pc        (redirect_pc)
  );

  task automatic cmp(input string tag, input string name, input logic [PC_W-1:0] act,
                     input logic [PC_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit iv, input logic [PC_W-1:0] pc,
                      input bit rv, input bit rm, input string tag);
    bit rdy;
    bit fire;
    rst                = r;
    issue_valid        = iv;
    issue_alt_pc       = pc;
    resolve_valid      = rv;
    resolve_mispredict = rm;
    @(posedge clk);
    if (r) begin
      m_shadow = 0; m_go = 0; m_cancel = 0; m_rpc = '0;
      pend_q.delete();
    end else begin
      rdy      = !m_shadow;
      fire     = rv && m_shadow;
      m_go     = fire && !rm;
      m_cancel = fire && rm;
      if (fire) begin
        if (rm) m_rpc = pend_q.pop_front();
        else    void'(pend_q.pop_front());
      end
      if (iv && rdy) begin
        pend_q.push_back(pc);
        m_shadow = 1;
      end else if (fire) begin
        m_shadow = 0;
      end
    end
    @(negedge clk);
    cmp(tag, "shadow_active",  {{(PC_W-1){1'b0}}, shadow_active},  {{(PC_W-1){1'b0}}, m_shadow});
    cmp(tag, "issue_ready",    {{(PC_W-1){1'b0}}, issue_ready},    {{(PC_W-1){1'b0}}, !m_shadow});
    cmp(tag, "go_write",       {{(PC_W-1){1'b0}}, go_write},       {{(PC_W-1){1'b0}}, m_go});
    cmp(tag, "cancel",         {{(PC_W-1){1'b0}}, cancel},         {{(PC_W-1){1'b0}}, m_cancel});
    cmp(tag, "redirect_valid", {{(PC_W-1){1'b0}}, redirect_valid}, {{(PC_W-1){1'b0}}, m_cancel});
    cmp(tag, "redirect_pc",    redirect_pc,                        m_rpc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; issue_valid = 0; issue_alt_pc = '0; resolve_valid = 0; resolve_mispredict = 0;
    @(negedge clk);
    step(1, 0, '0, 0, 0, "R1");
    step(1, 0, '0, 0, 0, "R1");
    step(0, 0, '0, 0, 0, "R1");
    // R6: outcomes while idle
    step(0, 0, '0, 1, 0, "R6");
    step(0, 0, '0, 1, 1, "R6");
    step(0, 0, '0, 0, 0, "R6");
    // R2 issue, R3 refused issue during shadow, R4 correct prediction
    step(0, 1, 32'h0000_1000, 0, 0, "R2");
    step(0, 1, 32'hDEAD_0000, 0, 0, "R3");
    step(0, 0, '0, 0, 0, "R3");
    step(0, 0, '0, 1, 0, "R4");
    step(0, 0, '0, 0, 0, "R4");
    // R5 mispredict with refused overwrite attempt (R3)
    step(0, 1, 32'h0000_2040, 0, 0, "R2");
    step(0, 1, 32'hBAD0_BAD0, 0, 0, "R3");
    step(0, 0, '0, 1, 1, "R5");
    step(0, 0, '0, 0, 0, "R5");
    // R7: outcome held high for several cycles
    step(0, 1, 32'h0000_3300, 0, 0, "R7");
    step(0, 0, '0, 1, 1, "R7");
    step(0, 0, '0, 1, 1, "R7");
    step(0, 0, '0, 1, 0, "R7");
    step(0, 0, '0, 0, 0, "R7");
    // R8: issue together with stale outcome while idle
    step(0, 1, 32'h0000_4404, 1, 1, "R8");
    step(0, 0, '0, 0, 0, "R8");
    // R9: issue in the cycle the cancel pulse is high
    step(0, 0, '0, 1, 1, "R9");
    step(0, 1, 32'h0000_5508, 0, 0, "R9");
    step(0, 0, '0, 1, 0, "R9");
    step(0, 1, 32'h0000_6610, 0, 0, "R9");
    step(0, 0, '0, 1, 1, "R9");
    step(0, 0, '0, 0, 0, "R9");
    // R1: reset with a branch in flight
    step(0, 1, 32'h0000_7777, 0, 0, "R1");
    step(1, 0, '0, 0, 0, "R1");
    step(0, 0, '0, 1, 1, "R1");
    step(0, 0, '0, 0, 0, "R1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule